// File: doc/BRIEF.md
# Advertising Event Wakeup Sequencer

This block controls a receiver that has no crystal reference. While idle it steps an open-loop local oscillator around the three advertising channels, 37, 38 and 39. It samples a one-bit energy detector once per microsecond and records the channel and apparent length of each burst it sees. The first two bursts are stored. When a third burst appears, the stored bursts and the third burst's channel are scored against a set of programmable templates. The two PLLs stay off until a template scores at or above a programmable threshold.

Once a template matches, the block holds the oscillator on the channel of the third packet and selects the clock-recovery receive path. It then enables the first PLL. A lock report from the first PLL enables the second PLL. When the second PLL reports lock and the recovered reference (present only while the third packet lasts) goes away, the block switches to transmit and issues a one-cycle start pulse. Any of three failures sends it back to scanning with both PLLs off and no transmission: a lock that does not arrive in time, or a reference that vanishes before the second lock. A 1 µs tick, divided from the baseband clock, times every interval.

Top module: `adv_wakeup_seq`

## Requirements
- R1: After reset, `lo_chan_o` reads 37. While scanning, it steps 37, 38, 39, then back to 37, and it never shows any other value.
- R2: One microsecond is `CLK_MHZ` clock cycles. With no event in progress, the first hop comes exactly `DWELL_US*CLK_MHZ` cycles after reset is released, and each dwell after that has the same length.
- R3: The block measures each burst from the first tick at which energy is seen on the oscillator's channel to the first tick at which that channel is seen quiet.
  - Channel codes are 0 for 37, 1 for 38 and 2 for 39.
  - Template t, slot s keeps its channel code in `tpl_chan_i[(t*3+s)*2 +: 2]`. Its length bounds sit in `tpl_len_min_i` and `tpl_len_max_i` at `[(t*2+s)*LEN_W +: LEN_W]` (inclusive), for s = 0 and 1.
  - A template scores one point for each of these that agrees: the two stored channels, the two stored lengths, and the third burst's channel.
  - The event matches when any template scores at least `score_min_i`.
- R4: `pll1_en_o` and `pll2_en_o` stay low until a third burst is seen while a template matches. In the cycle after that, `pll1_en_o` and `rx_path_cr_o` go high. `lo_chan_o` then holds while `pll1_en_o` stays high.
- R5: `pll2_en_o` is high only while `pll1_en_o` is high. It rises in the cycle after `pll1_lock_i` is first sampled high.
- R6: If either PLL fails to report lock within `LOCK_US` µs of its enable, both enables drop and scanning resumes. No transmit follows.
- R7: If `ref_present_i` is sampled low before the second PLL has locked, both enables drop in the next cycle and no transmit follows.
- R8: With both PLLs locked, the first cycle with `ref_present_i` low does four things: both enables drop, `tx_mode_o` rises, and `tx_start_o` gives a single one-cycle pulse. `tx_mode_o` falls `TX_US` µs later and scanning resumes.
- R9: If no burst starts within `GAP_US` µs of the last recorded one, the stored bursts are discarded. A later burst then counts as the first of a new event.
- R10: During and right after reset, all enables, `tx_mode_o` and `tx_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband clock, `CLK_MHZ` MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| energy_i | input | 1 | Digitized energy-detect bit for the current channel |
| ref_present_i | input | 1 | Recovered reference is present |
| pll1_lock_i | input | 1 | Receive PLL lock indication |
| pll2_lock_i | input | 1 | Transmit PLL lock indication |
| tpl_chan_i | input | NUM_TPL*6 | Template channel codes, three slots per template |
| tpl_len_min_i | input | NUM_TPL*2*LEN_W | Template minimum burst lengths in µs |
| tpl_len_max_i | input | NUM_TPL*2*LEN_W | Template maximum burst lengths in µs |
| score_min_i | input | 3 | Score needed for a match (0 to 5) |
| lo_chan_o | output | 6 | Channel index sent to the local oscillator |
| rx_path_cr_o | output | 1 | Selects the clock-recovery receive path |
| pll1_en_o | output | 1 | Receive PLL enable |
| pll2_en_o | output | 1 | Transmit PLL enable |
| tx_mode_o | output | 1 | Transmit mode |
| tx_start_o | output | 1 | One-cycle transmit start pulse |

## Verification
The properties take three things for granted about the inputs:
- Lock indications rise only while the matching enable is high.
- The reference flag is high only while the third packet is on the air.
- Energy comes from a single packet on one channel at a time.

The stimulus keeps to these rules with a small air model. It places each packet on one channel, starting when the oscillator reaches that channel. The reference flag follows the third packet's energy. The lock models count from each enable and drop lock as soon as the enable drops. Burst lengths are chosen well inside or well outside the template windows, so that the up-to-two-dwell error from hop phase cannot change a match result.

// File: rtl/adv_wake_pkg.sv
package adv_wake_pkg;

   // Sequencer states; the output decode depends on this set only.
   typedef enum logic [2:0] {
      ST_SCAN,
      ST_LOCK_RX,
      ST_LOCK_TX,
      ST_WAIT_END,
      ST_TX
   } seq_state_t;

   // Channel code 0..2 maps onto advertising index 37..39.
   typedef logic [1:0] chan_code_t;

   localparam int unsigned ADV_FIRST_IDX = 37;
   localparam int unsigned ADV_NUM_CHAN  = 3;
   localparam int unsigned SCORE_FIELDS  = 5;

endpackage

// File: rtl/awake_tick_gen.sv
module awake_tick_gen #(
   parameter int unsigned CLK_MHZ = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   initial begin : elab_chk
      assert (CLK_MHZ >= 1) else $fatal(1, "CLK_MHZ must be at least 1");
   end

   generate
      if (CLK_MHZ == 1) begin : g_direct
         // Every cycle is one microsecond.
         assign tick_o = rst_n;
         logic unused_clk;
         assign unused_clk = clk;
      end else begin : g_divide
         localparam int unsigned CW = $clog2(CLK_MHZ);
         logic [CW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          div_q <= '0;
            else if (div_q == CW'(CLK_MHZ - 1))  div_q <= '0;
            else                                 div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == CW'(CLK_MHZ - 1));
      end
   endgenerate

endmodule

// File: rtl/awake_hop_sched.sv
module awake_hop_sched
   import adv_wake_pkg::*;
#(
   parameter int unsigned DWELL_US = 50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       hold_i,
   output chan_code_t hop_o
);

   localparam int unsigned DW = $clog2(DWELL_US + 1);

   initial begin : elab_chk
      assert (DWELL_US >= 1) else $fatal(1, "DWELL_US must be at least 1");
   end

   logic [DW-1:0] dwell_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dwell_q <= '0;
         hop_o   <= '0;
      end else if (tick_i && !hold_i) begin
         if (dwell_q == DW'(DWELL_US - 1)) begin
            dwell_q <= '0;
            hop_o   <= (hop_o == chan_code_t'(ADV_NUM_CHAN - 1)) ? '0 : hop_o + 1'b1;
         end else begin
            dwell_q <= dwell_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/awake_pkt_meter.sv
module awake_pkt_meter
   import adv_wake_pkg::*;
#(
   parameter int unsigned LEN_W  = 10,
   parameter int unsigned GAP_US = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               scan_i,
   input  logic               energy_i,
   input  chan_code_t         hop_i,
   input  logic               match_i,
   output logic [3:0]         rec_chan_o,
   output logic [2*LEN_W-1:0] rec_len_o,
   output logic               third_o
);

   localparam int unsigned GW = $clog2(GAP_US + 1);

   initial begin : elab_chk
      assert (GAP_US >= 2) else $fatal(1, "GAP_US must be at least 2");
      assert (LEN_W >= 4)  else $fatal(1, "LEN_W must be at least 4");
   end

   logic             active_q;
   chan_code_t       cur_q;
   logic [LEN_W-1:0] len_q;
   logic [1:0]       slots_q;
   logic [GW-1:0]    idle_q;
   chan_code_t       rec_ch_q  [2];
   logic [LEN_W-1:0] rec_len_q [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= '0;
         len_q    <= '0;
         slots_q  <= '0;
         idle_q   <= '0;
         for (int i = 0; i < 2; i++) begin
            rec_ch_q[i]  <= '0;
            rec_len_q[i] <= '0;
         end
      end else if (!scan_i) begin
         active_q <= 1'b0;
         len_q    <= '0;
         slots_q  <= '0;
         idle_q   <= '0;
      end else if (tick_i) begin
         if (active_q) begin
            if (hop_i == cur_q && !energy_i) begin
               rec_ch_q[slots_q[0]]  <= cur_q;
               rec_len_q[slots_q[0]] <= len_q;
               slots_q  <= slots_q + 1'b1;
               active_q <= 1'b0;
               idle_q   <= '0;
            end else if (len_q != '1) begin
               len_q <= len_q + 1'b1;
            end
         end else if (energy_i) begin
            // A matched third burst is left for the sequencer to take.
            if (!(slots_q == 2'd2 && match_i)) begin
               if (slots_q == 2'd2) slots_q <= '0;
               active_q <= 1'b1;
               cur_q    <= hop_i;
               len_q    <= LEN_W'(1);
               idle_q   <= '0;
            end
         end else if (slots_q != '0) begin
            if (idle_q == GW'(GAP_US - 1)) begin
               slots_q <= '0;
               idle_q  <= '0;
            end else begin
               idle_q <= idle_q + 1'b1;
            end
         end
      end
   end

   assign rec_chan_o = {rec_ch_q[1], rec_ch_q[0]};
   assign rec_len_o  = {rec_len_q[1], rec_len_q[0]};
   assign third_o    = (slots_q == 2'd2) && !active_q;

endmodule

// File: rtl/awake_tpl_corr.sv
module awake_tpl_corr
   import adv_wake_pkg::*;
#(
   parameter int unsigned NUM_TPL = 2,
   parameter int unsigned LEN_W   = 10
) (
   input  logic [3:0]                 rec_chan_i,
   input  logic [2*LEN_W-1:0]         rec_len_i,
   input  chan_code_t                 cur_chan_i,
   input  logic [NUM_TPL*6-1:0]       tpl_chan_i,
   input  logic [NUM_TPL*2*LEN_W-1:0] tpl_len_min_i,
   input  logic [NUM_TPL*2*LEN_W-1:0] tpl_len_max_i,
   input  logic [2:0]                 score_min_i,
   output logic                       match_o
);

   initial begin : elab_chk
      assert (NUM_TPL >= 1 && NUM_TPL <= 16) else $fatal(1, "NUM_TPL out of range");
   end

   logic [NUM_TPL-1:0] tpl_ok;

   generate
      for (genvar t = 0; t < NUM_TPL; t++) begin : g_tpl
         logic [SCORE_FIELDS-1:0] hit;
         logic [2:0]              score;
         always_comb begin
            for (int s = 0; s < 2; s++) begin
               hit[2*s]   = rec_chan_i[2*s +: 2] == tpl_chan_i[(t*3+s)*2 +: 2];
               hit[2*s+1] = (rec_len_i[s*LEN_W +: LEN_W] >= tpl_len_min_i[(t*2+s)*LEN_W +: LEN_W]) &&
                            (rec_len_i[s*LEN_W +: LEN_W] <= tpl_len_max_i[(t*2+s)*LEN_W +: LEN_W]);
            end
            hit[4] = cur_chan_i == tpl_chan_i[(t*3+2)*2 +: 2];
            score  = '0;
            for (int b = 0; b < SCORE_FIELDS; b++) score = score + {2'b00, hit[b]};
         end
         assign tpl_ok[t] = score >= score_min_i;
      end
   endgenerate

   assign match_o = |tpl_ok;

endmodule

// File: rtl/adv_wakeup_seq.sv
module adv_wakeup_seq
   import adv_wake_pkg::*;
#(
   parameter int unsigned CLK_MHZ  = 16,
   parameter int unsigned DWELL_US = 50,
   parameter int unsigned LOCK_US  = 50,
   parameter int unsigned GAP_US   = 1000,
   parameter int unsigned TX_US    = 400,
   parameter int unsigned LEN_W    = 10,
   parameter int unsigned NUM_TPL  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       energy_i,
   input  logic                       ref_present_i,
   input  logic                       pll1_lock_i,
   input  logic                       pll2_lock_i,
   input  logic [NUM_TPL*6-1:0]       tpl_chan_i,
   input  logic [NUM_TPL*2*LEN_W-1:0] tpl_len_min_i,
   input  logic [NUM_TPL*2*LEN_W-1:0] tpl_len_max_i,
   input  logic [2:0]                 score_min_i,
   output logic [5:0]                 lo_chan_o,
   output logic                       rx_path_cr_o,
   output logic                       pll1_en_o,
   output logic                       pll2_en_o,
   output logic                       tx_mode_o,
   output logic                       tx_start_o
);

   localparam int unsigned TMAX = (LOCK_US > TX_US) ? LOCK_US : TX_US;
   localparam int unsigned TW   = $clog2(TMAX + 1);

   initial begin : elab_chk
      assert (LOCK_US >= 1 && TX_US >= 1) else $fatal(1, "timer limits must be non-zero");
   end

   seq_state_t         state_q;
   logic [TW-1:0]      timer_q;
   logic               tick;
   chan_code_t         hop;
   logic               scan;
   logic               third;
   logic               match;
   logic               wake;
   logic               tmr_end_lock;
   logic               tmr_end_tx;
   logic [3:0]         rec_chan;
   logic [2*LEN_W-1:0] rec_len;

   assign scan = (state_q == ST_SCAN);

   awake_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   awake_hop_sched #(.DWELL_US(DWELL_US)) u_hop (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .hold_i (!scan),
      .hop_o  (hop)
   );

   awake_pkt_meter #(.LEN_W(LEN_W), .GAP_US(GAP_US)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .scan_i     (scan),
      .energy_i   (energy_i),
      .hop_i      (hop),
      .match_i    (match),
      .rec_chan_o (rec_chan),
      .rec_len_o  (rec_len),
      .third_o    (third)
   );

   awake_tpl_corr #(.NUM_TPL(NUM_TPL), .LEN_W(LEN_W)) u_corr (
      .rec_chan_i    (rec_chan),
      .rec_len_i     (rec_len),
      .cur_chan_i    (hop),
      .tpl_chan_i    (tpl_chan_i),
      .tpl_len_min_i (tpl_len_min_i),
      .tpl_len_max_i (tpl_len_max_i),
      .score_min_i   (score_min_i),
      .match_o       (match)
   );

   assign wake         = scan && tick && energy_i && third && match;
   assign tmr_end_lock = tick && (timer_q == TW'(LOCK_US - 1));
   assign tmr_end_tx   = tick && (timer_q == TW'(TX_US - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_SCAN;
         timer_q    <= '0;
         tx_start_o <= 1'b0;
      end else begin
         tx_start_o <= 1'b0;
         unique case (state_q)
            ST_SCAN: begin
               timer_q <= '0;
               if (wake) state_q <= ST_LOCK_RX;
            end
            ST_LOCK_RX: begin
               if (!ref_present_i || (!pll1_lock_i && tmr_end_lock)) begin
                  state_q <= ST_SCAN;
               end else if (pll1_lock_i) begin
                  state_q <= ST_LOCK_TX;
                  timer_q <= '0;
               end else if (tick) begin
                  timer_q <= timer_q + 1'b1;
               end
            end
            ST_LOCK_TX: begin
               if (!ref_present_i || (!pll2_lock_i && tmr_end_lock)) begin
                  state_q <= ST_SCAN;
               end else if (pll2_lock_i) begin
                  state_q <= ST_WAIT_END;
               end else if (tick) begin
                  timer_q <= timer_q + 1'b1;
               end
            end
            ST_WAIT_END: begin
               timer_q <= '0;
               if (!ref_present_i) begin
                  state_q    <= ST_TX;
                  tx_start_o <= 1'b1;
               end
            end
            ST_TX: begin
               if (tmr_end_tx)  state_q <= ST_SCAN;
               else if (tick)   timer_q <= timer_q + 1'b1;
            end
            default: state_q <= ST_SCAN;
         endcase
      end
   end

   assign lo_chan_o    = 6'(ADV_FIRST_IDX) + {4'b0000, hop};
   assign pll1_en_o    = (state_q == ST_LOCK_RX) || (state_q == ST_LOCK_TX) || (state_q == ST_WAIT_END);
   assign rx_path_cr_o = pll1_en_o;
   assign pll2_en_o    = (state_q == ST_LOCK_TX) || (state_q == ST_WAIT_END);
   assign tx_mode_o    = (state_q == ST_TX);

endmodule

// File: rtl/adv_wakeup_seq_chk.sv
module adv_wakeup_seq_chk #(
   parameter int unsigned CLK_MHZ = 16,
   parameter int unsigned LOCK_US = 50
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_present_i,
   input logic       pll1_lock_i,
   input logic [5:0] lo_chan_o,
   input logic       pll1_en_o,
   input logic       pll2_en_o,
   input logic       tx_mode_o,
   input logic       tx_start_o
);

   localparam int unsigned LOCK_LIMIT = (LOCK_US + 1) * CLK_MHZ;

   int unsigned rx_lock_cycles;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rx_lock_cycles <= 0;
      else if (pll1_en_o && !pll2_en_o) rx_lock_cycles <= rx_lock_cycles + 1;
      else                              rx_lock_cycles <= 0;
   end

   assert_lo_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lo_chan_o inside {6'd37, 6'd38, 6'd39});

   assert_lo_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pll1_en_o && $past(pll1_en_o)) |-> $stable(lo_chan_o));

   assert_pll2_under_pll1_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pll2_en_o |-> pll1_en_o);

   assert_pll2_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll2_en_o) |-> $past(pll1_lock_i));

   assert_rx_lock_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lock_cycles <= LOCK_LIMIT);

   assert_ref_loss_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pll1_en_o && !ref_present_i) |=> !pll1_en_o);

   assert_tx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |=> !tx_start_o);

   assert_tx_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_o |-> (tx_mode_o && !pll1_en_o && !pll2_en_o && !$past(ref_present_i)));

endmodule

bind adv_wakeup_seq adv_wakeup_seq_chk #(.CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ref_present_i (ref_present_i),
   .pll1_lock_i   (pll1_lock_i),
   .lo_chan_o     (lo_chan_o),
   .pll1_en_o     (pll1_en_o),
   .pll2_en_o     (pll2_en_o),
   .tx_mode_o     (tx_mode_o),
   .tx_start_o    (tx_start_o)
);

// File: tb/adv_wakeup_seq_test.sv
module adv_wakeup_seq_test;

   localparam int CLK_MHZ = 2;
   localparam int LEN_W   = 10;
   localparam int NUM_TPL = 2;
   localparam int GAP_US  = 500;
   localparam int TX_US   = 100;

   typedef struct packed {
      logic [1:0] c1;
      logic [9:0] l1;
      logic [1:0] c2;
      logic [9:0] l2;
      logic [1:0] c3;
      logic [9:0] l3;
      logic [9:0] gap3;
      logic [6:0] lat1;
      logic [6:0] lat2;
      logic [2:0] thr;
      logic [3:0] req;
      logic       exp_p1;
      logic       exp_tx;
   } row_t;

   localparam int NROWS = 9;
   localparam row_t ROWS [NROWS] = '{
      '{2'd0, 10'd250, 2'd1, 10'd250, 2'd2, 10'd400, 10'd200, 7'd10, 7'd10, 3'd5, 4'd8, 1'b1, 1'b1},
      '{2'd2, 10'd350, 2'd1, 10'd350, 2'd0, 10'd400, 10'd200, 7'd10, 7'd10, 3'd5, 4'd3, 1'b1, 1'b1},
      '{2'd0, 10'd250, 2'd1, 10'd600, 2'd2, 10'd400, 10'd200, 7'd10, 7'd10, 3'd5, 4'd4, 1'b0, 1'b0},
      '{2'd0, 10'd250, 2'd2, 10'd250, 2'd1, 10'd400, 10'd200, 7'd10, 7'd10, 3'd5, 4'd4, 1'b0, 1'b0},
      '{2'd0, 10'd250, 2'd1, 10'd250, 2'd2, 10'd400, 10'd200, 7'd0,  7'd10, 3'd5, 4'd6, 1'b1, 1'b0},
      '{2'd0, 10'd250, 2'd1, 10'd250, 2'd2, 10'd400, 10'd200, 7'd10, 7'd0,  3'd5, 4'd6, 1'b1, 1'b0},
      '{2'd0, 10'd250, 2'd1, 10'd250, 2'd2, 10'd60,  10'd200, 7'd30, 7'd45, 3'd5, 4'd7, 1'b1, 1'b0},
      '{2'd0, 10'd250, 2'd1, 10'd600, 2'd2, 10'd400, 10'd200, 7'd10, 7'd10, 3'd4, 4'd3, 1'b1, 1'b1},
      '{2'd0, 10'd250, 2'd1, 10'd250, 2'd2, 10'd400, 10'd700, 7'd10, 7'd10, 3'd5, 4'd9, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic energy_i, ref_present_i;
   logic pll1_lock_i = 1'b0, pll2_lock_i = 1'b0;
   logic [NUM_TPL*6-1:0]       tpl_chan_i;
   logic [NUM_TPL*2*LEN_W-1:0] tpl_len_min_i, tpl_len_max_i;
   logic [2:0] score_min_i = 3'd5;
   logic [5:0] lo_chan_o;
   logic rx_path_cr_o, pll1_en_o, pll2_en_o, tx_mode_o, tx_start_o;

   logic       air_on = 1'b0;
   logic       air_third = 1'b0;
   logic [1:0] air_ch = 2'd0;
   int lat1 = 10, lat2 = 10;
   int n_cmp = 0, n_bad = 0;
   int p1_rises = 0, tx_cycles = 0;
   int c1 = 0, c2 = 0;
   logic lk1_prev = 1'b0, p1_prev = 1'b0, p2_prev = 1'b0;
   logic mon_on = 1'b0;

   always #2 clk = ~clk;

   // Template 0: 37,38,39 with lengths 100..400; template 1: 39,38,37 with 100..600.
   assign tpl_chan_i    = {2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd0};
   assign tpl_len_min_i = {10'd100, 10'd100, 10'd100, 10'd100};
   assign tpl_len_max_i = {10'd600, 10'd600, 10'd400, 10'd400};

   always_comb begin
      energy_i      = air_on && (lo_chan_o == 6'd37 + {4'b0000, air_ch});
      ref_present_i = air_on && air_third;
   end

   adv_wakeup_seq #(.CLK_MHZ(CLK_MHZ), .GAP_US(GAP_US), .TX_US(TX_US)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .energy_i      (energy_i),
      .ref_present_i (ref_present_i),
      .pll1_lock_i   (pll1_lock_i),
      .pll2_lock_i   (pll2_lock_i),
      .tpl_chan_i    (tpl_chan_i),
      .tpl_len_min_i (tpl_len_min_i),
      .tpl_len_max_i (tpl_len_max_i),
      .score_min_i   (score_min_i),
      .lo_chan_o     (lo_chan_o),
      .rx_path_cr_o  (rx_path_cr_o),
      .pll1_en_o     (pll1_en_o),
      .pll2_en_o     (pll2_en_o),
      .tx_mode_o     (tx_mode_o),
      .tx_start_o    (tx_start_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string req_name(input logic [3:0] r);
      case (r)
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd9:    return "R9";
         default: return "R8";
      endcase
   endfunction

   // Lock models and port monitors, all at the falling edge.
   always @(negedge clk) begin
      if (mon_on) begin
         if (pll1_en_o && !p1_prev) begin
            p1_rises++;
            chk(air_on && air_third, "R4 enable only during third packet", int'(air_third), 1);
         end
         if (pll2_en_o && !p2_prev)
            chk(pll1_lock_i && !lk1_prev && pll1_en_o, "R5 pll2 one cycle after lock",
                int'(lk1_prev), 0);
         if (tx_start_o) begin
            tx_cycles++;
            chk(tx_mode_o && !pll1_en_o && !pll2_en_o && !ref_present_i, "R8 tx entry",
                int'({tx_mode_o, pll1_en_o, pll2_en_o}), 4);
         end
      end
      p1_prev  = pll1_en_o;
      p2_prev  = pll2_en_o;
      lk1_prev = pll1_lock_i;
      if (!pll1_en_o) begin c1 = 0; pll1_lock_i = 1'b0; end
      else begin
         c1++;
         if (lat1 != 0 && c1 >= lat1 * CLK_MHZ) pll1_lock_i = 1'b1;
      end
      if (!pll2_en_o) begin c2 = 0; pll2_lock_i = 1'b0; end
      else begin
         c2++;
         if (lat2 != 0 && c2 >= lat2 * CLK_MHZ) pll2_lock_i = 1'b1;
      end
   end

   task automatic wait_us(input int us);
      repeat (us * CLK_MHZ) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send_pkt(input logic [1:0] ch, input int len, input logic is3);
      while (lo_chan_o != 6'd37 + {4'b0000, ch}) @(negedge clk);
      air_ch    = ch;
      air_third = is3;
      air_on    = 1'b1;
      wait_us(len);
      air_on    = 1'b0;
      air_third = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      // Reset state, R10
      repeat (2) @(negedge clk);
      chk(!pll1_en_o && !pll2_en_o && !tx_mode_o && !tx_start_o && !rx_path_cr_o,
          "R10 outputs in reset", int'({pll1_en_o, pll2_en_o, tx_mode_o}), 0);
      chk(lo_chan_o == 6'd37, "R1 channel in reset", int'(lo_chan_o), 37);

      // Hop order and dwell length, R1 and R2
      rst_n = 1'b1;
      repeat (50 * CLK_MHZ - 1) @(negedge clk);
      chk(lo_chan_o == 6'd37, "R2 last cycle of first dwell", int'(lo_chan_o), 37);
      @(negedge clk);
      chk(lo_chan_o == 6'd38, "R2 first hop edge", int'(lo_chan_o), 38);
      wait_us(50);
      chk(lo_chan_o == 6'd39, "R1 second hop", int'(lo_chan_o), 39);
      wait_us(50);
      chk(lo_chan_o == 6'd37, "R1 wrap to 37", int'(lo_chan_o), 37);
      chk(!pll1_en_o && !pll2_en_o, "R10 idle without packets", int'(pll1_en_o), 0);

      // Scenario table
      mon_on = 1'b1;
      for (int r = 0; r < NROWS; r++) begin
         lat1        = int'(ROWS[r].lat1);
         lat2        = int'(ROWS[r].lat2);
         score_min_i = ROWS[r].thr;
         do_reset();
         p1_rises  = 0;
         tx_cycles = 0;
         send_pkt(ROWS[r].c1, int'(ROWS[r].l1), 1'b0);
         wait_us(200);
         send_pkt(ROWS[r].c2, int'(ROWS[r].l2), 1'b0);
         wait_us(int'(ROWS[r].gap3));
         send_pkt(ROWS[r].c3, int'(ROWS[r].l3), 1'b1);
         wait_us(TX_US + 50);
         chk((p1_rises != 0) == ROWS[r].exp_p1,
             $sformatf("%s row %0d pll1 wake", req_name(ROWS[r].req), r),
             p1_rises, int'(ROWS[r].exp_p1));
         chk(tx_cycles == int'(ROWS[r].exp_tx),
             $sformatf("%s row %0d tx start cycles", req_name(ROWS[r].req), r),
             tx_cycles, int'(ROWS[r].exp_tx));
         chk(!tx_mode_o && !pll1_en_o && !pll2_en_o,
             $sformatf("R8 row %0d back to scan", r),
             int'({tx_mode_o, pll1_en_o, pll2_en_o}), 0);
      end

      // Directed: transmit mode lasts TX_US after the third packet ends, R8
      lat1 = 10;
      lat2 = 10;
      score_min_i = 3'd5;
      do_reset();
      send_pkt(2'd0, 250, 1'b0);
      wait_us(200);
      send_pkt(2'd1, 250, 1'b0);
      wait_us(200);
      send_pkt(2'd2, 300, 1'b1);
      wait_us(TX_US - 10);
      chk(tx_mode_o == 1'b1, "R8 tx mode held", int'(tx_mode_o), 1);
      wait_us(20);
      chk(tx_mode_o == 1'b0, "R8 tx mode released", int'(tx_mode_o), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule